// File: doc/BRIEF.md
# Fractional 100 Hz Tick Generator with BCD Hundredths

This block turns a 4096 Hz enable strobe into a 100 Hz tick. A single whole-number ratio cannot produce 100 Hz from 4096 Hz, so the divider switches between two moduli. Within a repeating group of 25 output ticks, 24 periods last 41 enables and one period lasts 40. The group therefore spans 1024 enables, which is exactly a quarter second. Individual periods jitter by one enable, but the phase is exact at every group boundary.

Each tick advances a two-digit BCD hundredths-of-seconds count. When the count wraps from 99 to 00, a one-cycle carry goes out to the seconds stage that follows. A load port writes a new hundredths value. The load also restarts the divider phase and the group position, so the next tick comes one full long period after the load.

The load port uses a valid/ready handshake with no back-pressure. `load_ready` is always high, and a load is taken on every clock edge where `load_valid` is high. The tick and carry outputs are plain pulses with no handshake, because a time base cannot be stalled.

Top module: `hs_tick_gen`

## Requirements
- R1: `tick_100` is high for exactly one clock cycle. It rises in the cycle after the edge at which an enable completes a period.
- R2: The group position starts at slot 0. Slots 0 to 23 each last 41 enables and slot 24 lasts 40 enables. After slot 24 the position returns to slot 0.
- R3: With the enable high on every clock, each group of 25 ticks spans exactly 1024 clock edges.
- R4: A clock edge with `en_4k` low neither advances the divider nor produces a tick.
- R5: `hundredths` is BCD, with units in bits [3:0] and tens in bits [7:4]. It increments by one in the cycle after each tick, and 99 is followed by 00.
- R6: `sec_carry` is high for one cycle only, in the same cycle that `hundredths` steps from 99 to 00 by increment. A load never raises it.
- R7: Reset sets `hundredths` to 00, holds `tick_100` and `sec_carry` low, and puts the divider at phase zero in slot 0.
- R8: `load_ready` is always 1. When `load_valid` is high at an edge, `hundredths` takes `load_value` and the divider restarts at phase zero in slot 0, so the next tick needs 41 enables. An enable at that same edge is ignored, and a tick present at that edge does not increment the count.
- R9: If a loaded nibble is above 9, that digit is stored as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en_4k | input | 1 | 4096 Hz enable strobe |
| load_valid | input | 1 | Load request for the hundredths value |
| load_ready | output | 1 | Load acceptance, always high |
| load_value | input | 8 | BCD value to load |
| tick_100 | output | 1 | 100 Hz tick pulse |
| hundredths | output | 8 | BCD hundredths count |
| sec_carry | output | 1 | Carry pulse to the seconds stage |

## Verification
The bench builds the block with the default moduli 41 and 40, a 25-slot group with the short slot at index 24, and two digits. With these values, a complete 1024-edge group runs in about a thousand cycles when the enable is held high, so the short slot and the return to slot 0 are covered early in the run. A full 00-to-99 wrap fits well inside the cycle budget, and a load of 97 brings the carry within three ticks. A run with a patterned, gappy enable shows that the divider counts enables and not clock edges.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef logic [3:0] bcd_digit_t;

  function automatic bcd_digit_t clean_digit(input bcd_digit_t d);
    return (d > 4'd9) ? 4'd0 : d;
  endfunction
endpackage

// File: rtl/hs_dual_mod_div.sv
module hs_dual_mod_div #(
  parameter int DIV_HI  = 41,
  parameter int DIV_LO  = 40,
  parameter int SEQ_LEN = 25,
  parameter int LO_SLOT = 24
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic restart,
  output logic tick
);
  localparam int CNT_W = $clog2(DIV_HI);
  localparam int SEQ_W = $clog2(SEQ_LEN);

  logic [CNT_W-1:0] cnt;
  logic [SEQ_W-1:0] seq;
  logic [CNT_W-1:0] last;
  logic             lo_now;
  logic             wrap;

  assign lo_now = (seq == SEQ_W'(LO_SLOT));
  assign last   = lo_now ? CNT_W'(DIV_LO - 1) : CNT_W'(DIV_HI - 1);
  assign wrap   = en && (cnt == last);

  always_ff @(posedge clk) begin
    if (rst || restart) begin
      cnt  <= '0;
      seq  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= wrap;
      if (en) begin
        if (wrap) begin
          cnt <= '0;
          seq <= (seq == SEQ_W'(SEQ_LEN - 1)) ? '0 : seq + 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end
  end

  a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= CNT_W'(DIV_HI - 1));
  a_r2_seq_bound: assert property (@(posedge clk) disable iff (rst)
    seq <= SEQ_W'(SEQ_LEN - 1));
  a_r1_single_pulse: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
  a_r8_restart_quiet: assert property (@(posedge clk) disable iff (rst)
    restart |=> !tick);
  a_r4_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!en && !restart) |=> ($stable(cnt) && !tick));
endmodule

// File: rtl/hs_bcd_digit.sv
module hs_bcd_digit
  import hs_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       inc,
  input  logic       load,
  input  bcd_digit_t load_val,
  output bcd_digit_t val,
  output logic       wrap
);
  assign wrap = inc && (val == 4'd9);

  always_ff @(posedge clk) begin
    if (rst)       val <= 4'd0;
    else if (load) val <= clean_digit(load_val);
    else if (inc)  val <= (val == 4'd9) ? 4'd0 : val + 4'd1;
  end

  a_r9_digit_range: assert property (@(posedge clk) disable iff (rst)
    val <= 4'd9);
  a_r5_digit_hold: assert property (@(posedge clk) disable iff (rst)
    (!inc && !load) |=> $stable(val));
endmodule

// File: rtl/hs_tick_gen.sv
module hs_tick_gen
  import hs_pkg::*;
#(
  parameter int DIV_HI  = 41,
  parameter int DIV_LO  = 40,
  parameter int SEQ_LEN = 25,
  parameter int LO_SLOT = 24,
  parameter int NDIG    = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en_4k,
  input  logic              load_valid,
  output logic              load_ready,
  input  logic [4*NDIG-1:0] load_value,
  output logic              tick_100,
  output logic [4*NDIG-1:0] hundredths,
  output logic              sec_carry
);
  logic            load_fire;
  logic [NDIG:0]   inc_chain;

  assign load_ready = 1'b1;
  assign load_fire  = load_valid;

  hs_dual_mod_div #(
    .DIV_HI (DIV_HI),
    .DIV_LO (DIV_LO),
    .SEQ_LEN(SEQ_LEN),
    .LO_SLOT(LO_SLOT)
  ) u_div (
    .clk    (clk),
    .rst    (rst),
    .en     (en_4k),
    .restart(load_fire),
    .tick   (tick_100)
  );

  assign inc_chain[0] = tick_100 && !load_fire;

  for (genvar g = 0; g < NDIG; g++) begin : g_digit
    hs_bcd_digit u_digit (
      .clk     (clk),
      .rst     (rst),
      .inc     (inc_chain[g]),
      .load    (load_fire),
      .load_val(load_value[4*g +: 4]),
      .val     (hundredths[4*g +: 4]),
      .wrap    (inc_chain[g+1])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) sec_carry <= 1'b0;
    else     sec_carry <= inc_chain[NDIG];
  end

  a_r6_carry_zero: assert property (@(posedge clk) disable iff (rst)
    sec_carry |-> (hundredths == '0));
  a_r6_carry_after_tick: assert property (@(posedge clk) disable iff (rst)
    sec_carry |-> $past(tick_100));
  a_r6_carry_single: assert property (@(posedge clk) disable iff (rst)
    sec_carry |=> !sec_carry);
  a_r8_ready_high: assert property (@(posedge clk) disable iff (rst)
    load_ready);
endmodule

// File: tb/hs_tick_gen_tb.sv
`timescale 1ns/1ps
module hs_tick_gen_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       en_4k = 1'b0;
  logic       load_valid = 1'b0;
  logic [7:0] load_value = 8'h00;
  logic       load_ready;
  logic       tick_100;
  logic [7:0] hundredths;
  logic       sec_carry;

  int checks = 0;
  int errors = 0;
  int edge_cnt = 0;
  int tick_seen = 0;
  bit done = 0;

  typedef struct {
    int         edge_no;
    logic [7:0] hs;
    logic       carry;
  } exp_t;
  exp_t q[$];

  int         mcnt = 0;
  int         mseq = 0;
  logic [7:0] mhs = 8'h00;
  bit         last_done = 0;

  hs_tick_gen u_dut (
    .clk(clk), .rst(rst), .en_4k(en_4k), .load_valid(load_valid),
    .load_ready(load_ready), .load_value(load_value), .tick_100(tick_100),
    .hundredths(hundredths), .sec_carry(sec_carry)
  );

  always #2.5 clk = ~clk;
  always @(posedge clk) edge_cnt++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] bcd_next(input logic [7:0] v);
    int n;
    n = (v[7:4] * 10 + v[3:0] + 1) % 100;
    return {4'(n / 10), 4'(n % 10)};
  endfunction

  function automatic logic [7:0] bcd_clean(input logic [7:0] v);
    return {(v[7:4] > 4'd9) ? 4'd0 : v[7:4], (v[3:0] > 4'd9) ? 4'd0 : v[3:0]};
  endfunction

  // driver: sets inputs at the falling edge and pushes expected ticks
  task automatic step(input logic e, input logic ld, input logic [7:0] v);
    exp_t x;
    logic [7:0] c;
    @(negedge clk);
    en_4k = e; load_valid = ld; load_value = v;
    if (ld) begin
      c = bcd_clean(v);
      if (last_done) begin
        x = q.pop_back();
        x.hs = c; x.carry = 1'b0;
        q.push_back(x);
      end
      mcnt = 0; mseq = 0; mhs = c; last_done = 0;
    end else if (e) begin
      if (mcnt == ((mseq == 24) ? 39 : 40)) begin
        mcnt = 0;
        mseq = (mseq == 24) ? 0 : mseq + 1;
        x.edge_no = edge_cnt + 1;
        x.carry = (mhs == 8'h99);
        mhs = bcd_next(mhs);
        x.hs = mhs;
        q.push_back(x);
        last_done = 1;
      end else begin
        mcnt++;
        last_done = 0;
      end
    end else begin
      last_done = 0;
    end
  endtask

  task automatic do_load(input logic [7:0] v, input logic e);
    step(e, 1'b1, v);
    @(posedge clk); #1;
    chk(hundredths == bcd_clean(v), "R8/R9 load value", hundredths, bcd_clean(v));
  endtask

  // monitor: compares observed ticks against the queue
  initial begin
    bit pend = 0;
    exp_t p;
    forever begin
      @(negedge clk); #1;
      if (!rst) begin
        if (pend) begin
          chk(hundredths == p.hs, "R5 hundredths after tick", hundredths, p.hs);
          chk(sec_carry == p.carry, "R6 carry", sec_carry, p.carry);
          pend = 0;
        end else if (sec_carry) begin
          chk(0, "R6 unexpected carry", 1, 0);
        end
        if (tick_100) begin
          tick_seen++;
          if (q.size() == 0) chk(0, "R1 unexpected tick", 1, 0);
          else begin
            p = q.pop_front();
            chk(edge_cnt == p.edge_no, "R1/R2 tick edge", edge_cnt, p.edge_no);
            pend = 1;
          end
        end
      end
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int start_edge;
    int start_ticks;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk); #1;
    // R7 reset state
    chk(hundredths == 8'h00, "R7 reset hundredths", hundredths, 0);
    chk(tick_100 == 1'b0, "R7 reset tick", tick_100, 0);
    chk(sec_carry == 1'b0, "R7 reset carry", sec_carry, 0);
    chk(load_ready == 1'b1, "R8 ready", load_ready, 1);

    // R2/R3: a full group with the enable held high
    start_edge = edge_cnt;
    start_ticks = tick_seen;
    for (int i = 0; i < 1024; i++) step(1'b1, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    chk(tick_seen - start_ticks == 25, "R3 ticks per group", tick_seen - start_ticks, 25);
    chk(mseq == 0 && mcnt == 0, "R3 group boundary model", mseq, 0);

    // R4: gappy enable
    for (int i = 0; i < 600; i++) step((i % 3) != 0, 1'b0, 8'h00);

    // R6: load 97 and cross the 99 boundary
    do_load(8'h97, 1'b0);
    for (int i = 0; i < 200; i++) step(1'b1, 1'b0, 8'h00);

    // R9: out-of-range nibbles
    do_load(8'hA5, 1'b0);
    do_load(8'h3F, 1'b0);

    // R8: load with the enable high at the same edge
    for (int i = 0; i < 20; i++) step(1'b1, 1'b0, 8'h00);
    do_load(8'h42, 1'b1);
    for (int i = 0; i < 90; i++) step(1'b1, 1'b0, 8'h00);

    // R8: load right when a tick is present
    do step(1'b1, 1'b0, 8'h00); while (!last_done);
    do_load(8'h99, 1'b0);
    for (int i = 0; i < 100; i++) step(1'b1, 1'b0, 8'h00);

    // long run through a full wrap from a fresh load
    do_load(8'h00, 1'b0);
    for (int i = 0; i < 4200; i++) step(1'b1, 1'b0, 8'h00);

    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    step(1'b0, 1'b0, 8'h00);
    chk(q.size() == 0, "R1 all expected ticks seen", q.size(), 0);
    if (start_edge < 0) chk(0, "R7 edge count", start_edge, 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule